// File: doc/BRIEF.md
# Oscillator Divider, Reset Qualifier and Power-Mode Controller

This block turns one raw oscillator input into the timing for a small 8-bit controller core. The oscillator is first halved, and the halved rate is counted into machine cycles of twelve oscillator periods. The block produces one strobe per machine cycle and two single-clock enables at the halved rate: one for the CPU and one for the peripherals (RAM, timers, serial port, interrupt logic). Downstream logic runs on the oscillator clock and advances only when its enable is high.

The raw reset pin goes out at once as a port reset. The reset that goes to the core is held back until the pin has stayed high for two machine cycles. A shorter pulse restarts the count and has no effect on the core. Software can request two low-power modes. Idle stops the CPU enable but keeps the peripheral enable and the machine-cycle strobe running, and an interrupt request ends it at the next machine-cycle boundary. Power-down stops every enable and the strobe, and only a qualified hardware reset ends it. All state sits in flip-flops, so the oscillator may stop and restart without losing anything.

Top module: `clkpm_ctrl`

## Requirements
- R1: `mcyc_stb` is high for exactly one oscillator clock in every 12 while not in power-down, so 120 clocks hold exactly 10 strobes.
- R2: `cpu_en` and `per_en` are never high on two clocks in a row. In run mode each is high on exactly 6 of every 12 clocks, whatever the duty cycle of the input clock.
- R3: `port_rst` follows `rst_pin` with no register in the path, so it is high in the same time step that `rst_pin` rises.
- R4: `core_rst` rises only after `rst_pin` has been seen high for 2 machine cycles (at least 24 oscillator clocks). It is high within 32 clocks of the rise of `rst_pin` when the pin stays high.
- R5: A `rst_pin` pulse shorter than 24 clocks never raises `core_rst`, clears the qualification count, and leaves the power mode unchanged.
- R6: While `core_rst` is high the mode returns to run, and `core_rst` falls within a few clocks after `rst_pin` falls.
- R7: In idle, `cpu_en` stays low while `per_en` (6 per 12 clocks) and `mcyc_stb` (1 per 12 clocks) keep running.
- R8: In idle, a `wake_irq` pulse returns the block to run. The change takes effect on the clock edge that ends the current machine cycle, so the first `cpu_en` comes two clocks after a sampled `mcyc_stb`.
- R9: In power-down, `cpu_en`, `per_en` and `mcyc_stb` all stay low, and `wake_irq` and `idle_req` have no effect.
- R10: The requests `idle_req` and `pdown_req` are taken only in run mode. If both are high together, power-down wins.
- R11: Stopping the oscillator and starting it again keeps the current mode.
- R12: Reset qualification runs on the free-running divided clock, so a held `rst_pin` ends power-down as well as idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_pin | input | 1 | Asynchronous reset pin, active high |
| idle_req | input | 1 | Request from the control register to enter idle |
| pdown_req | input | 1 | Request from the control register to enter power-down |
| wake_irq | input | 1 | Enabled interrupt request, ends idle |
| cpu_en | output | 1 | Clock enable for the CPU |
| per_en | output | 1 | Clock enable for RAM, timers, serial port and interrupt logic |
| mcyc_stb | output | 1 | One-clock strobe at the end of each machine cycle |
| core_rst | output | 1 | Qualified core reset |
| port_rst | output | 1 | Unqualified reset for the I/O ports |

## Verification
The bench pulses `rst_pin` for 20 clocks twice, with a short gap between the pulses. A qualifier that does not clear its count on a gap, or that counts raw clocks instead of divided ticks, would reset the core and drop the idle mode it left in place. It sends a wake request while in power-down and a power-down request while in idle; a controller that takes either would change the counted enables. It checks that a wake leaves idle exactly at the machine-cycle edge, raises both requests in the same clock to test priority, and stops the oscillator in the middle of idle to show that the mode survives.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_IDLE  = 2'd1,
      PM_PDOWN = 2'd2
   } pm_mode_e;

endpackage

// File: rtl/clkpm_divider.sv
module clkpm_divider #(
   parameter int unsigned MCYC_OSC = 12
) (
   input  logic osc_clk,
   output logic base_en,
   output logic mcyc_end
);
   localparam int unsigned TICKS = MCYC_OSC / 2;
   localparam int unsigned PH_W  = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS - 1);

   generate
      if ((MCYC_OSC % 2) != 0 || MCYC_OSC < 4) begin : g_bad_len
         $error("clkpm_divider: MCYC_OSC must be even and at least 4");
      end
   endgenerate

   logic            half_q;
   logic [PH_W-1:0] phase_q;

   // the halving flop makes internal timing independent of input duty cycle
   always_ff @(posedge osc_clk) begin
      half_q <= ~half_q;
      if (half_q) begin
         phase_q <= (phase_q >= PH_LAST) ? '0 : phase_q + 1'b1;
      end
   end

   assign base_en  = half_q;
   assign mcyc_end = half_q && (phase_q == PH_LAST);

endmodule

// File: rtl/clkpm_rst_qual.sv
module clkpm_rst_qual #(
   parameter int unsigned TICKS       = 6,
   parameter int unsigned QUAL_MCYC   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic rst_pin,
   input  logic tick,
   output logic core_rst
);
   localparam int unsigned THRESH = TICKS * QUAL_MCYC;
   localparam int unsigned CNT_W  = $clog2(THRESH + 1);
   localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESH);

   generate
      if (QUAL_MCYC < 1 || TICKS < 2) begin : g_bad_qual
         $error("clkpm_rst_qual: QUAL_MCYC must be >= 1 and TICKS >= 2");
      end
   endgenerate

   logic rst_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rst_s = rst_pin;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge osc_clk) s_q <= rst_pin;
         assign rst_s = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge osc_clk) s_q <= {s_q[SYNC_STAGES-2:0], rst_pin};
         assign rst_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   // counts divided ticks, so it keeps going whatever the power mode
   always_ff @(posedge osc_clk) begin
      if (!rst_s) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != THR_C)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign core_rst = (cnt_q == THR_C);

   // R4
   rst_after_qual_chk: assert property (@(posedge osc_clk)
      $rose(core_rst) |-> $past(rst_s));

   // R5
   rst_drop_chk: assert property (@(posedge osc_clk) disable iff (rst_pin)
      !rst_s |=> !core_rst);

endmodule

// File: rtl/clkpm_mode_ctrl.sv
module clkpm_mode_ctrl
   import clkpm_pkg::*;
#(
   parameter bit WAKE_ON_BOUNDARY = 1'b1
) (
   input  logic     osc_clk,
   input  logic     core_rst,
   input  logic     mcyc_end,
   input  logic     idle_req,
   input  logic     pdown_req,
   input  logic     wake_irq,
   output pm_mode_e mode
);
   pm_mode_e mode_q;
   logic     wake_pend;
   logic     wake_now;

   generate
      if (WAKE_ON_BOUNDARY) begin : g_wake_edge
         assign wake_now = mcyc_end && (wake_pend || wake_irq);
      end else begin : g_wake_any
         assign wake_now = wake_pend || wake_irq;
      end
   endgenerate

   always_ff @(posedge osc_clk) begin
      if (core_rst) begin
         mode_q    <= PM_RUN;
         wake_pend <= 1'b0;
      end else begin
         case (mode_q)
            PM_RUN: begin
               wake_pend <= 1'b0;
               if (pdown_req)     mode_q <= PM_PDOWN;
               else if (idle_req) mode_q <= PM_IDLE;
            end
            PM_IDLE: begin
               if (wake_now) begin
                  mode_q    <= PM_RUN;
                  wake_pend <= 1'b0;
               end else if (wake_irq) begin
                  wake_pend <= 1'b1;
               end
            end
            PM_PDOWN: begin
               wake_pend <= 1'b0;
            end
            default: begin
               mode_q    <= PM_RUN;
               wake_pend <= 1'b0;
            end
         endcase
      end
   end

   assign mode = mode_q;

   generate
      if (WAKE_ON_BOUNDARY) begin : g_wake_chk
         // R8
         wake_on_edge_chk: assert property (@(posedge osc_clk) disable iff (core_rst)
            ($past(mode_q) == PM_IDLE && mode_q == PM_RUN && !$past(core_rst))
               |-> $past(mcyc_end));
      end
   endgenerate

   // R9
   pdown_hold_chk: assert property (@(posedge osc_clk) disable iff (core_rst)
      (mode_q == PM_PDOWN) |=> (mode_q == PM_PDOWN));

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
   import clkpm_pkg::*;
#(
   parameter int unsigned MCYC_OSC         = 12,
   parameter int unsigned QUAL_MCYC        = 2,
   parameter int unsigned SYNC_STAGES      = 2,
   parameter bit          WAKE_ON_BOUNDARY = 1'b1
) (
   input  logic osc_clk,
   input  logic rst_pin,
   input  logic idle_req,
   input  logic pdown_req,
   input  logic wake_irq,
   output logic cpu_en,
   output logic per_en,
   output logic mcyc_stb,
   output logic core_rst,
   output logic port_rst
);
   localparam int unsigned TICKS = MCYC_OSC / 2;

   logic     base_en;
   logic     mcyc_end;
   pm_mode_e mode;

   clkpm_divider #(
      .MCYC_OSC (MCYC_OSC)
   ) i_div (
      .osc_clk  (osc_clk),
      .base_en  (base_en),
      .mcyc_end (mcyc_end)
   );

   clkpm_rst_qual #(
      .TICKS       (TICKS),
      .QUAL_MCYC   (QUAL_MCYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_rq (
      .osc_clk  (osc_clk),
      .rst_pin  (rst_pin),
      .tick     (base_en),
      .core_rst (core_rst)
   );

   clkpm_mode_ctrl #(
      .WAKE_ON_BOUNDARY (WAKE_ON_BOUNDARY)
   ) i_mode (
      .osc_clk   (osc_clk),
      .core_rst  (core_rst),
      .mcyc_end  (mcyc_end),
      .idle_req  (idle_req),
      .pdown_req (pdown_req),
      .wake_irq  (wake_irq),
      .mode      (mode)
   );

   assign port_rst = rst_pin;
   assign cpu_en   = base_en  && (mode == PM_RUN);
   assign per_en   = base_en  && (mode != PM_PDOWN);
   assign mcyc_stb = mcyc_end && (mode != PM_PDOWN);

   // R1
   mcyc_single_chk: assert property (@(posedge osc_clk) disable iff (core_rst)
      mcyc_stb |=> !mcyc_stb);

   // R2
   per_half_rate_chk: assert property (@(posedge osc_clk) disable iff (core_rst)
      per_en |=> !per_en);

   // R7
   idle_cpu_off_chk: assert property (@(posedge osc_clk) disable iff (core_rst)
      (mode == PM_IDLE) |-> !cpu_en);

   // R9
   pdown_quiet_chk: assert property (@(posedge osc_clk) disable iff (core_rst)
      (mode == PM_PDOWN) |-> (!per_en && !mcyc_stb && !cpu_en));

endmodule

// File: tb/test_clkpm_ctrl.sv
module test_clkpm_ctrl;

   logic osc_clk   = 1'b0;
   logic clk_run   = 1'b1;
   logic rst_pin   = 1'b0;
   logic idle_req  = 1'b0;
   logic pdown_req = 1'b0;
   logic wake_irq  = 1'b0;
   logic cpu_en, per_en, mcyc_stb, core_rst, port_rst;

   int n_chk  = 0;
   int n_fail = 0;
   int c_cpu, c_per, c_mcyc;

   // 250 MHz
   always begin
      #2;
      if (clk_run) osc_clk = ~osc_clk;
   end

   clkpm_ctrl i_clkpm_ctrl (
      .osc_clk   (osc_clk),
      .rst_pin   (rst_pin),
      .idle_req  (idle_req),
      .pdown_req (pdown_req),
      .wake_irq  (wake_irq),
      .cpu_en    (cpu_en),
      .per_en    (per_en),
      .mcyc_stb  (mcyc_stb),
      .core_rst  (core_rst),
      .port_rst  (port_rst)
   );

   // {idle_req, pdown_req, wake_irq, cpu count, per count, strobe count}
   localparam logic [14:0] VEC [9] = '{
      {1'b0, 1'b0, 1'b0, 4'd6, 4'd6, 4'd1},   // R2 run
      {1'b1, 1'b0, 1'b0, 4'd0, 4'd6, 4'd1},   // R7 idle
      {1'b0, 1'b0, 1'b1, 4'd6, 4'd6, 4'd1},   // R8 wake
      {1'b1, 1'b0, 1'b0, 4'd0, 4'd6, 4'd1},   // R7 idle again
      {1'b0, 1'b1, 1'b0, 4'd0, 4'd6, 4'd1},   // R10 pdown ignored in idle
      {1'b0, 1'b0, 1'b1, 4'd6, 4'd6, 4'd1},   // R8 wake
      {1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0},   // R9 pdown
      {1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0},   // R9 wake ignored
      {1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0}    // R9 idle ignored
   };

   task automatic step(input int n);
      repeat (n) @(negedge osc_clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(input int n);
      c_cpu = 0; c_per = 0; c_mcyc = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge osc_clk);
         c_cpu  += int'(cpu_en);
         c_per  += int'(per_en);
         c_mcyc += int'(mcyc_stb);
      end
   endtask

   task automatic pulse(input logic i, input logic p, input logic w);
      idle_req = i; pdown_req = p; wake_irq = w;
      step(1);
      idle_req = 1'b0; pdown_req = 1'b0; wake_irq = 1'b0;
   endtask

   task automatic hard_reset;
      rst_pin = 1'b1;
      step(40);
      rst_pin = 1'b0;
      step(30);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int seen;
      int hist1, hist2;
      step(2);
      hard_reset();
      // reset state
      check("R6 core_rst after release", int'(core_rst), 0);
      check("R3 port_rst after release", int'(port_rst), 0);

      for (int r = 0; r < 9; r++) begin
         pulse(VEC[r][14], VEC[r][13], VEC[r][12]);
         step(24);
         measure(12);
         check($sformatf("R7/R8/R9/R10 row %0d cpu_en", r), c_cpu,  int'(VEC[r][11:8]));
         check($sformatf("R7/R8/R9/R10 row %0d per_en", r), c_per,  int'(VEC[r][7:4]));
         check($sformatf("R1/R9 row %0d mcyc_stb", r),      c_mcyc, int'(VEC[r][3:0]));
      end

      // R12: leave power-down through the reset pin, R3 immediate port reset
      rst_pin = 1'b1;
      #1;
      check("R3 port_rst same step", int'(port_rst), 1);
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge osc_clk);
         seen |= int'(core_rst);
      end
      check("R4 no core_rst before 24 clocks", seen, 0);
      step(12);
      check("R4 R12 core_rst after 32 clocks", int'(core_rst), 1);
      rst_pin = 1'b0;
      step(6);
      check("R6 core_rst falls", int'(core_rst), 0);
      step(24);
      measure(12);
      check("R6 R12 run after reset cpu_en", c_cpu, 6);

      // R1 R2 long window
      measure(120);
      check("R1 strobes in 120 clocks", c_mcyc, 10);
      check("R2 cpu_en in 120 clocks", c_cpu, 60);

      // R5: short pulses while idle
      pulse(1'b1, 1'b0, 1'b0);
      step(24);
      seen = 0;
      rst_pin = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(negedge osc_clk);
         seen |= int'(core_rst);
      end
      rst_pin = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge osc_clk);
         seen |= int'(core_rst);
      end
      rst_pin = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(negedge osc_clk);
         seen |= int'(core_rst);
      end
      rst_pin = 1'b0;
      step(24);
      check("R5 short pulses no core_rst", seen, 0);
      measure(12);
      check("R5 idle kept cpu_en", c_cpu, 0);
      check("R5 idle kept per_en", c_per, 6);

      // R11: stop the oscillator in idle
      clk_run = 1'b0;
      #200;
      clk_run = 1'b1;
      measure(12);
      check("R11 idle after clock stop cpu_en", c_cpu, 0);
      check("R11 idle after clock stop mcyc", c_mcyc, 1);

      // R8: wake lands on the machine-cycle edge
      hist1 = 0; hist2 = 0; seen = 0;
      pulse(1'b0, 1'b0, 1'b1);
      hist1 = int'(mcyc_stb);
      for (int k = 0; k < 30 && seen == 0; k++) begin
         @(negedge osc_clk);
         if (cpu_en) seen = 1;
         else begin
            hist2 = hist1;
            hist1 = int'(mcyc_stb);
         end
      end
      check("R8 wake seen", seen, 1);
      check("R8 strobe two clocks before cpu_en", hist2, 1);

      // R10: both requests together, power-down wins
      step(24);
      pulse(1'b1, 1'b1, 1'b0);
      step(24);
      measure(12);
      check("R10 priority cpu_en", c_cpu, 0);
      check("R10 priority per_en", c_per, 0);
      hard_reset();
      measure(12);
      check("R12 run after second reset per_en", c_per, 6);

      summary();
      $finish;
   end

endmodule